// File: doc/BRIEF.md
# Outstanding-Miss Tracker for a Non-Blocking Data Cache

This block keeps a small data cache usable while earlier misses are still waiting on memory. The core presents one request per cycle. Each request carries a cache-line address and a hit/miss flag that comes from the tag lookup, which sits outside this block. Hits are answered at once, even while misses are pending. A miss to a line that is not already pending takes a free entry in a table of outstanding misses and sends one fetch to memory, tagged with that entry's index. A miss to a line that is already pending joins the existing entry and sends no new fetch.

Memory returns fills in any order. Each fill names the entry index it completes. The tracker frees that entry and reports the line to the core, together with the number of requests that were waiting on it. When no entry is free for a new line, the request is held off through `req_ready` until a fill frees a slot. A request is also held off when the entry it would join has reached its waiter limit.

Top module: `miss_tracker`

## Requirements
- R1: A request with `req_hit`=1 is always accepted (`req_ready`=1), even while entries are pending or the table is full. One cycle later `hit_rsp_valid` pulses with the same line, and no memory fetch is issued for that request.
- R2: A miss to a line not held in the table, with a free entry, is accepted. One cycle later `mem_req_valid` pulses with the line and `mem_req_idx` set to the lowest-numbered free entry.
- R3: Up to ENTRIES (4) misses to distinct lines can be outstanding at the same time. Each occupies its own entry index.
- R4: A miss to a line already pending is accepted without a memory fetch. That entry's waiter count rises by one. The count starts at 1 when the entry is allocated.
- R5: When all entries are valid, a miss to a line not in the table sees `req_ready`=0 and issues no fetch. A slot freed by a fill is not usable in the cycle of that fill. It is usable from the next cycle on.
- R6: `fill_valid` with `fill_idx` naming a valid entry frees that entry. One cycle later `fill_rsp_valid` pulses with that entry's line in `fill_rsp_line` and its waiter count in `fill_rsp_waiters`. Fills may arrive in any order.
- R7: A miss to a pending line whose entry already has MAX_WAIT (4) waiters sees `req_ready`=0.
- R8: A miss to a pending line whose entry is being filled in the same cycle sees `req_ready`=0 in that cycle.
- R9: A fill naming an entry that is not valid produces no `fill_rsp_valid` and changes no entry.
- R10: After reset the table is empty, all response and fetch outputs are low, and a miss sees `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_line | input | LINE_W | Line address of the request |
| req_hit | input | 1 | Tag lookup result: 1 = hit, 0 = miss |
| req_ready | output | 1 | Request accepted this cycle |
| hit_rsp_valid | output | 1 | Hit answered (one cycle after acceptance) |
| hit_rsp_line | output | LINE_W | Line of the answered hit |
| mem_req_valid | output | 1 | Fetch issued to memory |
| mem_req_line | output | LINE_W | Line to fetch |
| mem_req_idx | output | IDX_W | Entry index the fill must return |
| fill_valid | input | 1 | Fill arriving from memory |
| fill_idx | input | IDX_W | Entry index the fill completes |
| fill_rsp_valid | output | 1 | Waiting requests released |
| fill_rsp_line | output | LINE_W | Line that was filled |
| fill_rsp_waiters | output | CNT_W | Number of requests released |

## Verification
The main function is exercised with four patterns. The first is a burst of misses to distinct lines; it separates fresh allocation from merging and shows that the lowest free entry is chosen. The second mixes repeated misses to one line; here waiter counts and the absence of extra fetches reveal merging. The third interleaves hits with pending misses and with a full table; it shows that hits are never blocked. The fourth returns fills out of order, some of them in the same cycle as a request, which separates release by index from release by arrival. It also checks when a freed slot first becomes usable, and it covers fills that name idle entries.

// File: rtl/miss_tracker.sv
module miss_tracker #(
  parameter int ENTRIES = 4,
  parameter int LINE_W = 26,
  parameter int MAX_WAIT = 4,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = $clog2(MAX_WAIT + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  input  logic              req_hit,
  output logic              req_ready,
  output logic              hit_rsp_valid,
  output logic [LINE_W-1:0] hit_rsp_line,
  output logic              mem_req_valid,
  output logic [LINE_W-1:0] mem_req_line,
  output logic [IDX_W-1:0]  mem_req_idx,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_idx,
  output logic              fill_rsp_valid,
  output logic [LINE_W-1:0] fill_rsp_line,
  output logic [CNT_W-1:0]  fill_rsp_waiters
);

  logic [ENTRIES-1:0] vld, match;
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [CNT_W-1:0]   cnt_q  [ENTRIES];
  logic [IDX_W-1:0]   m_idx, f_idx;
  logic               m_any, f_any;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (line_q[g] == req_line);
  end

  always_comb begin
    m_idx = '0;
    f_idx = '0;
    m_any = 1'b0;
    f_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        m_any = 1'b1;
        m_idx = IDX_W'(i);
      end
      if (!vld[i]) begin
        f_any = 1'b1;
        f_idx = IDX_W'(i);
      end
    end
  end

  wire fill_ok  = fill_valid && vld[fill_idx];
  wire m_busy   = fill_ok && (fill_idx == m_idx);
  wire m_full   = cnt_q[m_idx] == CNT_W'(MAX_WAIT);
  assign req_ready = req_hit || (m_any ? !(m_busy || m_full) : f_any);
  wire acc      = req_valid && req_ready;
  wire do_alloc = acc && !req_hit && !m_any;
  wire do_merge = acc && !req_hit && m_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        line_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_ok && fill_idx == IDX_W'(i)) vld[i] <= 1'b0;
        if (do_alloc && f_idx == IDX_W'(i)) begin
          vld[i]    <= 1'b1;
          line_q[i] <= req_line;
          cnt_q[i]  <= CNT_W'(1);
        end
        if (do_merge && m_idx == IDX_W'(i)) cnt_q[i] <= cnt_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_rsp_valid    <= 1'b0;
      hit_rsp_line     <= '0;
      mem_req_valid    <= 1'b0;
      mem_req_line     <= '0;
      mem_req_idx      <= '0;
      fill_rsp_valid   <= 1'b0;
      fill_rsp_line    <= '0;
      fill_rsp_waiters <= '0;
    end else begin
      hit_rsp_valid    <= acc && req_hit;
      hit_rsp_line     <= req_line;
      mem_req_valid    <= do_alloc;
      mem_req_line     <= req_line;
      mem_req_idx      <= f_idx;
      fill_rsp_valid   <= fill_ok;
      fill_rsp_line    <= line_q[fill_idx];
      fill_rsp_waiters <= cnt_q[fill_idx];
    end
  end

  // R1
  hit_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rsp_valid |-> !mem_req_valid);

  // R2
  fetch_entry_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (vld[mem_req_idx] && line_q[mem_req_idx] == mem_req_line));

  // R5
  full_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_hit && (&vld) && !(|match)) |=> !mem_req_valid);

  // R6
  fill_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && vld[fill_idx]) |=> (fill_rsp_valid && !vld[$past(fill_idx)]));

  // R6
  fill_has_waiter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_rsp_valid |-> (fill_rsp_waiters != '0));

  // R9
  idle_fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !vld[fill_idx]) |=> !fill_rsp_valid);

endmodule

// File: tb/miss_tracker_bench.sv
module miss_tracker_bench;
  localparam int LW = 26;
  localparam int NE = 4;
  localparam int IW = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_hit = 1'b0, fill_valid = 1'b0;
  logic [LW-1:0] req_line = '0;
  logic [IW-1:0] fill_idx = '0;
  logic req_ready, hit_rsp_valid, mem_req_valid, fill_rsp_valid;
  logic [LW-1:0] hit_rsp_line, mem_req_line, fill_rsp_line;
  logic [IW-1:0] mem_req_idx;
  logic [CW-1:0] fill_rsp_waiters;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  miss_tracker u_miss_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
    .req_hit(req_hit), .req_ready(req_ready), .hit_rsp_valid(hit_rsp_valid),
    .hit_rsp_line(hit_rsp_line), .mem_req_valid(mem_req_valid),
    .mem_req_line(mem_req_line), .mem_req_idx(mem_req_idx),
    .fill_valid(fill_valid), .fill_idx(fill_idx),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_line(fill_rsp_line),
    .fill_rsp_waiters(fill_rsp_waiters));

  logic [LW-1:0]    hit_q  [$];
  logic [IW+LW-1:0] mem_q  [$];
  logic [CW+LW-1:0] fill_q [$];

  bit          m_vld [NE];
  logic [LW-1:0] m_line [NE];
  int          m_cnt [NE];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input bit rv, input logic [LW-1:0] ln, input bit h,
                      input bit fv, input int fi, input bit exp_rdy, input string req);
    int mi, fr;
    @(negedge clk);
    req_valid = rv; req_line = ln; req_hit = h;
    fill_valid = fv; fill_idx = IW'(fi);
    #1;
    if (rv) check(req_ready == exp_rdy, req, req_ready, exp_rdy);
    if (fv && m_vld[fi]) fill_q.push_back({CW'(m_cnt[fi]), m_line[fi]});
    if (rv && exp_rdy) begin
      if (h) hit_q.push_back(ln);
      else begin
        mi = -1; fr = -1;
        for (int i = NE - 1; i >= 0; i--) begin
          if (m_vld[i] && m_line[i] == ln) mi = i;
          if (!m_vld[i]) fr = i;
        end
        if (mi >= 0) m_cnt[mi]++;
        else begin
          mem_q.push_back({IW'(fr), ln});
          m_vld[fr] = 1; m_line[fr] = ln; m_cnt[fr] = 1;
          if (fv && fi == fr) fr = -1;
        end
      end
    end
    if (fv && m_vld[fi] && !(rv && exp_rdy && !h && m_line[fi] == ln && m_cnt[fi] == 1 && 0)) m_vld[fi] = 0;
    @(posedge clk);
    #1;
    req_valid = 1'b0; fill_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (hit_rsp_valid) begin
        if (hit_q.size() == 0) check(0, "R1 unexpected hit response", hit_rsp_line, 0);
        else begin
          logic [LW-1:0] e;
          e = hit_q.pop_front();
          check(hit_rsp_line == e, "R1 hit line", hit_rsp_line, e);
        end
      end
      if (mem_req_valid) begin
        if (mem_q.size() == 0) check(0, "R2 unexpected fetch", {mem_req_idx, mem_req_line}, 0);
        else begin
          logic [IW+LW-1:0] e;
          e = mem_q.pop_front();
          check({mem_req_idx, mem_req_line} == e, "R2 fetch index/line", {mem_req_idx, mem_req_line}, e);
        end
      end
      if (fill_rsp_valid) begin
        if (fill_q.size() == 0) check(0, "R9 unexpected fill response", {fill_rsp_waiters, fill_rsp_line}, 0);
        else begin
          logic [CW+LW-1:0] e;
          e = fill_q.pop_front();
          check({fill_rsp_waiters, fill_rsp_line} == e, "R6 fill waiters/line",
                {fill_rsp_waiters, fill_rsp_line}, e);
        end
      end
    end
  end

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin m_vld[i] = 0; m_line[i] = '0; m_cnt[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_hit = 1'b0; req_line = 26'h77;
    #1;
    // R10: empty table after reset
    check(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
    check({hit_rsp_valid, mem_req_valid, fill_rsp_valid} == 3'b000, "R10 outputs idle",
          {hit_rsp_valid, mem_req_valid, fill_rsp_valid}, 0);
    req_valid = 1'b0;

    step(1, 26'h10,  1, 0, 0, 1, "R1 hit on empty table");
    step(1, 26'h100, 0, 0, 0, 1, "R2 first miss");
    step(1, 26'h200, 0, 0, 0, 1, "R3 second miss");
    step(1, 26'h11,  1, 0, 0, 1, "R1 hit under miss");
    step(1, 26'h100, 0, 0, 0, 1, "R4 merge into pending line");
    step(1, 26'h300, 0, 0, 0, 1, "R3 third miss");
    step(1, 26'h400, 0, 0, 0, 1, "R3 fourth miss");
    step(1, 26'h500, 0, 0, 0, 0, "R5 stall when full");
    step(1, 26'h12,  1, 0, 0, 1, "R1 hit while full");
    step(1, 26'h200, 0, 0, 0, 1, "R4 merge while full");
    step(1, 26'h500, 0, 1, 2, 0, "R5 freed slot not usable in fill cycle");
    step(1, 26'h500, 0, 0, 0, 1, "R5 freed slot usable next cycle");
    step(0, 26'h0,   0, 1, 0, 0, "R6 out-of-order fill");
    step(0, 26'h0,   0, 1, 0, 0, "R9 fill to idle entry");
    step(1, 26'h100, 0, 0, 0, 1, "R9 entry left free after idle fill");
    step(1, 26'h200, 0, 1, 1, 0, "R8 merge blocked by same-cycle fill");
    step(1, 26'h100, 0, 0, 0, 1, "R7 merge to 2 waiters");
    step(1, 26'h100, 0, 0, 0, 1, "R7 merge to 3 waiters");
    step(1, 26'h100, 0, 0, 0, 1, "R7 merge to 4 waiters");
    step(1, 26'h100, 0, 0, 0, 0, "R7 waiter limit stall");
    step(0, 26'h0,   0, 1, 0, 0, "R6 release four waiters");
    step(0, 26'h0,   0, 1, 3, 0, "R6 fill last entry");
    step(0, 26'h0,   0, 1, 2, 0, "R6 fill reused entry");
    repeat (3) @(negedge clk);
    check(hit_q.size() == 0, "R1 all hits answered", hit_q.size(), 0);
    check(mem_q.size() == 0, "R2 all fetches issued", mem_q.size(), 0);
    check(fill_q.size() == 0, "R6 all fills answered", fill_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule